// File: doc/BRIEF.md
# Master-ID Region Access Checker

This block sits between a bus and one protected slave port. Every request arrives with the identifier of the master that issued it. The block looks up the address in a small table of region rules and decides whether that master may read or write there. Each rule has a base, an inclusive limit, a bitmap of masters it admits, a read permission bit and a write permission bit. Rules are ranked by index. A request that is not allowed never reaches the slave. Instead, it finishes at once with an error response.

A configuration port programs the rules during start-up. The rules with the lowest index can set aside regions for the trusted core alone, which uses master ID 0. Each rule has a lock bit. Once a rule is locked, it stays frozen until the next reset. The block also keeps the address and master ID of the most recent refused request, so firmware can find out what was blocked.

Top module: `mid_access_guard`

## Requirements
- R1: After reset every rule has base all ones, limit zero and an attribute word of zero, so no rule matches, every request is refused, and `err_valid` is 0.
- R2: A rule matches when base <= address <= limit, with both ends inclusive. When several rules match, the one with the lowest index alone decides the outcome.
- R3: A request that matches no rule is refused.
- R4: The deciding rule allows a request only if two conditions hold. First, attribute bit [m] is set, where m is the request's master ID (bits [7:0] form the master bitmap). Second, bit 8 (read) is set for a read, or bit 9 (write) is set for a write.
- R5: Bit 31 of the attribute word is the lock bit. Once it is set, writes to that rule's base, limit and attribute words have no effect, and the lock stays set until reset.
- R6: An allowed request is passed to the slave: `dn_valid` follows `up_valid`, and `up_ready` and `up_rdata` follow the slave. A refused request never raises `dn_valid`.
- R7: A refused request completes in the same cycle with `up_ready`=1, `up_err`=1 and `up_rdata`=0.
- R8: On the clock edge that completes a refused request, `err_addr` and `err_mid` capture that request, and `err_valid` goes to 1 and stays there until reset.
- R9: `cfg_rdata` shows, without a clock delay, the word of rule `cfg_idx` chosen by `cfg_sel`: 0 selects the base, 1 the limit, 2 the attribute word, and 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Request address |
| up_wdata | input | DATA_W | Write data |
| up_mid | input | MID_W | Master ID of the requester |
| up_rdata | output | DATA_W | Read data returned upstream |
| up_err | output | 1 | Error response for a refused request |
| dn_valid | output | 1 | Request valid toward the slave |
| dn_ready | input | 1 | Slave accepts the request |
| dn_write | output | 1 | Direction toward the slave |
| dn_addr | output | ADDR_W | Address toward the slave |
| dn_wdata | output | DATA_W | Write data toward the slave |
| dn_rdata | input | DATA_W | Read data from the slave |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Rule index |
| cfg_sel | input | 2 | Word select: 0 base, 1 limit, 2 attribute |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| err_valid | output | 1 | At least one request refused since reset |
| err_addr | output | ADDR_W | Address of the last refused request |
| err_mid | output | MID_W | Master ID of the last refused request |

## Verification
The bench targets the following corner cases:
- **Overlapping rules.** A low-index rule reserved for master 0 lies inside a wider rule that admits everyone. A checker that picked the highest index, or that OR-ed matches together, would let other masters into the reserved window.
- **Region edges.** Accesses land exactly on the limit and one past it. An off-by-one limit compare would open or close the last word of a region.
- **Permission splits.** A read-only rule receives a write, and an unlisted master receives a read.
- **Locked rules.** A locked rule is rewritten and then read back. A lock that failed to hold would change the table and the outcome of a later access.
- **Slave stall.** A permitted access is held while the slave stalls, showing that a permitted request waits for the slave while a refused one never drives it.

// File: rtl/mag_pkg.sv
package mag_pkg;
  localparam int CFG_W      = 32;
  localparam int MAP_W      = 8;
  localparam int RD_BIT     = 8;
  localparam int WR_BIT     = 9;
  localparam int LOCK_BIT   = 31;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_ATTR  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  // Permission verdict of one attribute word for a master index and direction.
  function automatic logic attr_grants(input logic [CFG_W-1:0] attr,
                                       input logic [2:0] mid,
                                       input logic is_write);
    logic dir_ok;
    dir_ok = is_write ? attr[WR_BIT] : attr[RD_BIT];
    return attr[mid] && dir_ok;
  endfunction

  function automatic logic attr_locked(input logic [CFG_W-1:0] attr);
    return attr[LOCK_BIT];
  endfunction
endpackage

// File: rtl/mag_rule_file.sv
module mag_rule_file
  import mag_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [1:0]                    cfg_sel,
  input  logic [CFG_W-1:0]              cfg_wdata,
  output logic [CFG_W-1:0]              cfg_rdata,
  output logic [N_ENT-1:0][ADDR_W-1:0]  base_o,
  output logic [N_ENT-1:0][ADDR_W-1:0]  limit_o,
  output logic [N_ENT-1:0][CFG_W-1:0]   attr_o
);
  logic [N_ENT-1:0] locked;
  logic [N_ENT-1:0] wr_take;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign locked[i]  = attr_locked(attr_o[i]);
    assign wr_take[i] = cfg_we && (cfg_idx == IDX_W'(i)) && !locked[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[i]  <= '1;
        limit_o[i] <= '0;
        attr_o[i]  <= '0;
      end else if (wr_take[i]) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_BASE:  base_o[i]  <= cfg_wdata[ADDR_W-1:0];
          SEL_LIMIT: limit_o[i] <= cfg_wdata[ADDR_W-1:0];
          SEL_ATTR:  attr_o[i]  <= cfg_wdata;
          default: ;
        endcase
      end
    end

    // R5: a locked rule keeps its contents and its lock
    a_r5_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked[i] |=> ($stable(base_o[i]) && $stable(limit_o[i]) && $stable(attr_o[i])));
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      locked[i] |=> locked[i]);
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel_e'(cfg_sel))
      SEL_BASE:  cfg_rdata = CFG_W'(base_o[cfg_idx]);
      SEL_LIMIT: cfg_rdata = CFG_W'(limit_o[cfg_idx]);
      SEL_ATTR:  cfg_rdata = attr_o[cfg_idx];
      default:   cfg_rdata = '0;
    endcase
  end

  // R9: unused selector reads as zero
  a_r9_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd3) |-> (cfg_rdata == '0));
endmodule

// File: rtl/mag_decider.sv
module mag_decider
  import mag_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32,
  parameter int MID_W  = 3,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          is_write,
  input  logic [MID_W-1:0]              mid,
  input  logic [N_ENT-1:0][ADDR_W-1:0]  base_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0]  limit_i,
  input  logic [N_ENT-1:0][CFG_W-1:0]   attr_i,
  output logic                          hit_any,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          permit
);
  function automatic logic in_region(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [N_ENT-1:0] hits;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hits[i] = in_region(addr, base_i[i], limit_i[i]);
  end

  // Scan from the top index down so the lowest matching index is left standing.
  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hits[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |hits;
  assign permit  = hit_any && attr_grants(attr_i[hit_idx], 3'(mid), is_write);
endmodule

// File: rtl/mag_deny_log.sv
module mag_deny_log #(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MID_W-1:0]  mid,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [MID_W-1:0]  err_mid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_addr  <= '0;
      err_mid   <= '0;
    end else if (deny_fire) begin
      err_valid <= 1'b1;
      err_addr  <= addr;
      err_mid   <= mid;
    end
  end

  // R8: capture of the refused request
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    deny_fire |=> (err_valid && err_addr == $past(addr) && err_mid == $past(mid)));
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> err_valid);
endmodule

// File: rtl/mid_access_guard.sv
module mid_access_guard
  import mag_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W  = 3,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [MID_W-1:0]  up_mid,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [MID_W-1:0]  err_mid
);
  logic [N_ENT-1:0][ADDR_W-1:0] rule_base;
  logic [N_ENT-1:0][ADDR_W-1:0] rule_limit;
  logic [N_ENT-1:0][CFG_W-1:0]  rule_attr;
  logic                         hit_any;
  logic [IDX_W-1:0]             hit_idx;
  logic                         permit;
  logic                         deny_fire;

  mag_rule_file #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_rules (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_sel, .cfg_wdata, .cfg_rdata,
    .base_o(rule_base), .limit_o(rule_limit), .attr_o(rule_attr)
  );

  mag_decider #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .MID_W(MID_W)) u_dec (
    .addr(up_addr), .is_write(up_write), .mid(up_mid),
    .base_i(rule_base), .limit_i(rule_limit), .attr_i(rule_attr),
    .hit_any, .hit_idx, .permit
  );

  assign deny_fire = up_valid && !permit;

  mag_deny_log #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_log (
    .clk, .rst_n, .deny_fire, .addr(up_addr), .mid(up_mid),
    .err_valid, .err_addr, .err_mid
  );

  assign dn_valid = up_valid && permit;
  assign dn_write = up_write;
  assign dn_addr  = up_addr;
  assign dn_wdata = up_wdata;
  assign up_ready = permit ? dn_ready : 1'b1;
  assign up_rdata = permit ? dn_rdata : '0;
  assign up_err   = deny_fire;

  // R6: refused requests never reach the slave
  a_r6_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !permit) |-> !dn_valid);
  // R7: refused requests end at once with an error and no data
  a_r7_err_now: assert property (@(posedge clk) disable iff (!rst_n)
    deny_fire |-> (up_ready && up_err && up_rdata == '0));
  // R3: nothing matched means nothing allowed
  a_r3_miss_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !hit_any) |-> (up_err && !dn_valid));
  // R2: the deciding rule really contains the address
  a_r2_idx_contains: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && hit_any) |->
      (up_addr >= rule_base[hit_idx] && up_addr <= rule_limit[hit_idx]));
endmodule

// File: tb/mid_access_guard_test.sv
`timescale 1ns/1ps
module mid_access_guard_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [2:0]  up_mid = '0;
  logic        up_ready, up_err, dn_valid, dn_write;
  logic [31:0] up_rdata, dn_addr, dn_wdata, dn_rdata;
  logic        dn_ready = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        err_valid;
  logic [31:0] err_addr;
  logic [2:0]  err_mid;

  always #4 clk = ~clk;

  assign dn_rdata = {dn_addr[15:0], 16'hC35A};

  mid_access_guard uut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Independent model of the rule table
  logic [31:0] m_base [N];
  logic [31:0] m_lim  [N];
  logic [31:0] m_attr [N];

  function automatic bit mdl_permit(input logic [31:0] a, input logic [2:0] m,
                                    input bit wr);
    for (int i = 0; i < N; i++) begin
      if (a >= m_base[i] && a <= m_lim[i])
        return m_attr[i][m] && (wr ? m_attr[i][9] : m_attr[i][8]);
    end
    return 1'b0;
  endfunction

  typedef struct {
    bit          err;
    bit          rd;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t sb[$];

  // Monitor: pops one expected item per completed handshake
  always @(posedge clk) begin
    if (rst_n && up_valid && up_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "scoreboard", 0, 1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(up_err == e.err, e.req, 64'(up_err), 64'(e.err));
        check(dn_valid == !e.err, {e.req, " R6 fwd"}, 64'(dn_valid), 64'(!e.err));
        if (e.rd || e.err)
          check(up_rdata == e.data, {e.req, " data"}, 64'(up_rdata), 64'(e.data));
      end
    end
  end

  task automatic cfg_write(input int idx, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!m_attr[idx][31]) begin
      if (sel == 0) m_base[idx] = d;
      else if (sel == 1) m_lim[idx] = d;
      else if (sel == 2) m_attr[idx] = d;
    end
  endtask

  task automatic cfg_check(input int idx, input int sel, input string req);
    logic [31:0] e;
    @(negedge clk);
    cfg_idx = 3'(idx); cfg_sel = 2'(sel);
    #1;
    e = (sel == 0) ? m_base[idx] : (sel == 1) ? m_lim[idx] :
        (sel == 2) ? m_attr[idx] : 32'h0;
    check(cfg_rdata == e, req, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] m, input bit wr,
                        input string req, input int stall = 0);
    exp_t e;
    bit   p;
    p = mdl_permit(a, m, wr);
    e.err = !p; e.rd = !wr; e.req = req;
    e.data = p ? {a[15:0], 16'hC35A} : 32'h0;
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_mid = m; up_write = wr; up_wdata = ~a;
    dn_ready = (stall == 0);
    sb.push_back(e);
    for (int s = 0; s < stall; s++) begin
      #1;
      check(up_ready == 1'b0 && dn_valid == 1'b1, {req, " R6 stall"},
            64'({up_ready, dn_valid}), 64'b01);
      @(negedge clk);
    end
    dn_ready = 1'b1;
    do @(posedge clk); while (!up_ready);
    @(negedge clk);
    up_valid = 1'b0;
    if (!p)
      check(err_valid && err_addr == a && err_mid == m, {req, " R8 log"},
            64'({err_valid, err_mid, err_addr}), 64'({1'b1, m, a}));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog all-requirements act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_base[i] = 32'hFFFF_FFFF; m_lim[i] = 32'h0; m_attr[i] = 32'h0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cfg_check(3, 0, "R1 base");
    cfg_check(3, 2, "R1 attr");
    @(negedge clk);
    check(err_valid == 1'b0, "R1 err_valid", 64'(err_valid), 0);
    access(32'h100, 3'd0, 1'b0, "R1 reset deny");

    // Program: rule0 secure-only window, rule1 wide open, rule2 read-only for masters 1..7
    cfg_write(0, 0, 32'h1000); cfg_write(0, 1, 32'h1FFF);
    cfg_write(0, 2, 32'h8000_0301);
    cfg_write(1, 0, 32'h0);    cfg_write(1, 1, 32'hFFFF);
    cfg_write(1, 2, 32'h0000_03FF);
    cfg_write(2, 0, 32'h20000); cfg_write(2, 1, 32'h2FFFF);
    cfg_write(2, 2, 32'h0000_01FE);
    cfg_check(0, 1, "R9 limit readback");
    cfg_check(2, 2, "R9 attr readback");
    cfg_check(2, 3, "R9 sel3 zero");

    access(32'h1000, 3'd0, 1'b1, "R4 secure write");
    access(32'h1800, 3'd3, 1'b0, "R2 priority deny");
    access(32'h1FFF, 3'd5, 1'b0, "R2 limit edge deny");
    access(32'h1FFF, 3'd0, 1'b0, "R2 limit edge allow");
    access(32'h2000, 3'd3, 1'b0, "R2 past limit allow");
    access(32'h0FFF, 3'd3, 1'b1, "R2 below base allow");
    access(32'h20000, 3'd1, 1'b0, "R4 read allow");
    access(32'h20004, 3'd1, 1'b1, "R4 write deny");
    access(32'h2FFFF, 3'd0, 1'b0, "R4 master bit clear");
    access(32'h30000, 3'd2, 1'b0, "R3 no match");
    access(32'h0400, 3'd6, 1'b0, "R6 stalled slave", 3);

    // R5 locked rule ignores rewrites
    cfg_write(0, 2, 32'h0000_03FF);
    cfg_write(0, 0, 32'h0);
    cfg_check(0, 2, "R5 attr kept");
    cfg_check(0, 0, "R5 base kept");
    access(32'h1800, 3'd3, 1'b0, "R5 still reserved");
    cfg_write(1, 2, 32'h0000_01FF);
    cfg_check(1, 2, "R5 unlocked rewrite");
    access(32'h0800, 3'd2, 1'b1, "R4 write after rewrite");
    access(32'h0800, 3'd2, 1'b0, "R7 read after rewrite");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R6 drained", 64'(sb.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule